// File: doc/BRIEF.md
# Instruction-Byte Serial Register Port

This block is a serial slave that gives an external master read and write access to a bank of byte-wide configuration registers. An active-low chip select frames each transaction. A transaction has two phases. The master first shifts in one instruction byte. That byte gives the direction of the transfer, how many data bytes follow (one to four) and the register address of the first byte. The data bytes then move in the direction the instruction named, and the register address steps after each byte.

All serial inputs are sampled in the system clock domain through a synchronizer. Edges of the serial clock are detected after that synchronizer. Data in both directions shares one half-duplex pin. The block presents it as an input, an output and an output enable, which drive an external tristate buffer. The enable is raised only while read data bits are being returned. One register bit selects whether bytes travel most significant bit first or least significant bit first. The selected order also sets whether the address counts down or up.

The controller is a four-state machine. INSTR collects the instruction byte. WRITE takes in data bytes and commits each one. READ drives data bytes out. DONE ignores further clock edges once the byte count is used up. The transitions are as follows. INSTR goes to READ or WRITE on the eighth rising edge, according to the direction bit. WRITE or READ goes to DONE on the last bit of the final byte. Any state returns to INSTR whenever chip select is high.

Top module: `spi_reg_port`

## Requirements
- R1: After reset every register reads 0x00, the output enable is low and the port uses most-significant-bit-first order.
- R2: The first eight rising serial-clock edges after chip select falls carry the instruction byte. In MSB-first layout, bit 7 is the direction (1 = read), bits 6:5 hold the byte count minus one, and bits 4:0 hold the start address.
- R3: In MSB-first order, each write byte arrives bit 7 first and is stored at the current address. The address then decrements by one.
- R4: In LSB-first order, the instruction and data bytes arrive bit 0 first, and the address increments by one after each byte.
- R5: Read data changes only on serial-clock falling edges. The first bit is presented on the falling edge that follows the last instruction bit, and the bit order matches the active mode. The output enable is high only during the read data phase.
- R6: Register 0x00 bit 6 selects LSB-first order (1) or MSB-first order (0). A change to this bit takes effect at the start of the next transaction.
- R7: Raising chip select at any point aborts the transaction. The output enable drops, a partly received byte is not stored, and the next transaction starts with a fresh instruction byte.
- R8: Once the instructed number of bytes has moved, further serial-clock edges in the same transaction write nothing and do not drive the pin.
- R9: The address wraps modulo 32 in both directions: 31 steps up to 0, and 0 steps down to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| csb | input | 1 | Active-low chip select framing a transaction |
| sdio_in | input | 1 | Data pin as seen from the pad input |
| sdio_out | output | 1 | Data pin value to drive during reads |
| sdio_oe | output | 1 | Enable for the pad's output driver |
| cfg_q | output | 256 | Contents of all registers, register n at bits 8n+7:8n |

## Verification
Several properties are checked on every clock. The output enable is only ever high in the read state and never in the instruction phase. It drops one cycle after a synchronized chip-select release. The pin value moves only on detected falling edges. Register contents change only on detected rising edges and never once the byte count is exhausted. Other behaviours need the bench's scenarios: the decoding of the instruction fields, address stepping and wrap in each order, the mode bit taking effect only at the next transaction, and the discarding of partial bytes on abort. These are shown by comparing read-back data and the register outputs against a model of the bank.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [1:0] {
        ST_INSTR = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DONE  = 2'd3
    } port_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int                STAGES  = 2,
    parameter int                WIDTH   = 3,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= RST_VAL;
                else        chain_q[0] <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sclk_s;
    end

    assign rise = sclk_s & ~prev_q;
    assign fall = ~sclk_s & prev_q;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [AW-1:0]              raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] flat
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (we && (waddr == AW'(i))) regs_q[i] <= wdata;
            end
        end
    end

    assign rdata = regs_q[raddr];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign flat[g*DATA_W +: DATA_W] = regs_q[g];
        end
    endgenerate

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MODE_REG    = 0,
    parameter int MODE_BIT    = 6,
    localparam int AW         = $clog2(NUM_REGS),
    localparam int CNT_W      = $clog2(DATA_W),
    localparam int LEN_W      = DATA_W - 1 - AW,
    localparam int CFG_W      = NUM_REGS * DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             csb,
    input  logic             sdio_in,
    output logic             sdio_out,
    output logic             sdio_oe,
    output logic [CFG_W-1:0] cfg_q
);

    logic        csb_s, sclk_s, sdi_s;
    logic        sclk_rise, sclk_fall;

    port_state_e      state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [DATA_W-1:0] shift_q, shift_in;
    logic [AW-1:0]    addr_q, addr_step;
    logic [LEN_W-1:0] left_q;
    logic             lsb_q, sdo_q, oe_q;
    logic             byte_end, mode_now;
    logic [CNT_W-1:0] out_idx;
    logic             bank_we;
    logic [DATA_W-1:0] bank_rdata;

    spi_pin_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({csb, sclk, sdio_in}),
        .q    ({csb_s, sclk_s, sdi_s})
    );

    spi_sclk_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk_s(sclk_s),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    // Byte assembly: LSB-first fills from the top, MSB-first from the bottom.
    assign shift_in  = lsb_q ? {sdi_s, shift_q[DATA_W-1:1]}
                             : {shift_q[DATA_W-2:0], sdi_s};
    assign byte_end  = sclk_rise && (bit_cnt_q == CNT_W'(DATA_W-1));
    assign addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
    assign out_idx   = lsb_q ? bit_cnt_q : CNT_W'(DATA_W-1) - bit_cnt_q;
    assign mode_now  = cfg_q[MODE_REG*DATA_W + MODE_BIT];
    assign bank_we   = byte_end && (state_q == ST_WRITE) && !csb_s;

    always_comb begin
        state_d = state_q;
        if (csb_s) begin
            state_d = ST_INSTR;
        end else begin
            unique case (state_q)
                ST_INSTR: if (byte_end) state_d = shift_in[DATA_W-1] ? ST_READ : ST_WRITE;
                ST_WRITE: if (byte_end && left_q == '0) state_d = ST_DONE;
                ST_READ:  if (byte_end && left_q == '0) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INSTR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            addr_q    <= '0;
            left_q    <= '0;
            lsb_q     <= 1'b0;
            sdo_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else if (csb_s) begin
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
            lsb_q     <= mode_now;
        end else begin
            if (sclk_rise && state_q != ST_DONE) begin
                shift_q   <= shift_in;
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (byte_end) begin
                unique case (state_q)
                    ST_INSTR: begin
                        addr_q <= shift_in[AW-1:0];
                        left_q <= shift_in[DATA_W-2 -: LEN_W];
                    end
                    ST_WRITE, ST_READ: begin
                        addr_q <= addr_step;
                        left_q <= left_q - 1'b1;
                    end
                    ST_DONE: ;
                endcase
            end
            if (sclk_fall && state_q == ST_READ) begin
                sdo_q <= bank_rdata[out_idx];
                oe_q  <= 1'b1;
            end
            if (state_d != ST_READ) oe_q <= 1'b0;
        end
    end

    spi_reg_bank #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bank_we),
        .waddr(addr_q),
        .wdata(shift_in),
        .raddr(addr_q),
        .rdata(bank_rdata),
        .flat (cfg_q)
    );

    assign sdio_out = sdo_q;
    assign sdio_oe  = oe_q;

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
    import spi_reg_pkg::*;
#(
    parameter int CFG_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csb_s,
    input logic             sclk_rise,
    input logic             sclk_fall,
    input port_state_e      state,
    input logic             sdio_oe,
    input logic             sdio_out,
    input logic [CFG_W-1:0] cfg
);

    // R7
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csb_s |=> !sdio_oe);

    // R5
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (state == ST_READ));

    // R2
    instr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSTR) |-> !sdio_oe);

    // R5
    sdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdio_out));

    // R3
    write_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(cfg));

    // R8
    done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> $stable(cfg));

endmodule

bind spi_reg_port spi_reg_port_chk #(.CFG_W(NUM_REGS*DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csb_s    (csb_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .state    (state_q),
    .sdio_oe  (sdio_oe),
    .sdio_out (sdio_out),
    .cfg      (cfg_q)
);

// File: tb/spi_reg_port_tb.sv
module spi_reg_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NV         = 9;

    // {read, count-1, addr, data bytes (byte k at bits 8k+7:8k)}
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 2'd0, 5'd5,  32'h000000A5},
        {1'b0, 2'd3, 5'd3,  32'h44332211},
        {1'b1, 2'd3, 5'd0,  32'h00000000},
        {1'b0, 2'd1, 5'd30, 32'h0000C35A},
        {1'b0, 2'd1, 5'd31, 32'h0000F00F},
        {1'b0, 2'd0, 5'd0,  32'h00000000},
        {1'b1, 2'd2, 5'd1,  32'h00000000},
        {1'b0, 2'd2, 5'd1,  32'h007E3C9C},
        {1'b1, 2'd1, 5'd31, 32'h00000000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         csb = 1'b1;
    logic         sdio_in = 1'b0;
    logic         sdio_out, sdio_oe;
    logic [255:0] cfg_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [32];
    logic       model_lsb = 1'b0;

    spi_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .cfg_q(cfg_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [255:0] model_flat();
        logic [255:0] f;
        for (int i = 0; i < 32; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3";
            1: return "R6";
            2: return "R4";
            3: return "R4";
            4: return "R9";
            5: return "R6";
            6: return "R5";
            7: return "R3";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_bit(input logic b, input logic exp_oe, input string req,
                          output logic rb);
        sdio_in = b;
        repeat (HALF) @(negedge clk);
        rb = sdio_out;
        chk(sdio_oe == exp_oe, req, "output enable", 256'(sdio_oe), 256'(exp_oe));
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] v, input logic lsb, input logic exp_oe,
                           input string req, output logic [7:0] r);
        for (int i = 0; i < 8; i++) begin
            int idx;
            logic rb;
            idx = lsb ? i : 7 - i;
            do_bit(v[idx], exp_oe, req, rb);
            r[idx] = rb;
        end
    endtask

    task automatic cs_low();
        csb = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        csb = 1'b1;
        repeat (3*HALF) @(negedge clk);
        model_lsb = model[0][6];
    endtask

    task automatic xact(input logic [39:0] v, input string req);
        logic       rd;
        int         n, a;
        logic [7:0] instr, r, ins_wire, exp;
        rd = v[39];
        n  = int'(v[38:37]) + 1;
        a  = int'(v[36:32]);
        instr = v[39:32];
        cs_low();
        do_byte(instr, model_lsb, 1'b0, "R2", r);
        for (int k = 0; k < n; k++) begin
            ins_wire = v[8*k +: 8];
            do_byte(ins_wire, model_lsb, rd, req, r);
            if (rd) begin
                exp = model[a];
                chk(r == exp, req, "read byte", 256'(r), 256'(exp));
            end else begin
                model[a] = ins_wire;
            end
            a = model_lsb ? (a + 1) % 32 : (a + 31) % 32;
        end
        cs_high();
        chk(cfg_q == model_flat(), req, "register bank", cfg_q, model_flat());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic rb;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cfg_q == '0, "R1", "registers after reset", cfg_q, '0);
        chk(sdio_oe == 1'b0, "R1", "enable after reset", 256'(sdio_oe), 256'(0));
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(cfg_q == '0, "R1", "registers after release", cfg_q, '0);

        for (int i = 0; i < NV; i++) xact(VEC[i], vec_tag(i));

        // R7 abort during write data: partial byte dropped
        cs_low();
        do_byte({1'b0, 2'd0, 5'd7}, model_lsb, 1'b0, "R7", r);
        for (int i = 0; i < 5; i++) do_bit(1'b1, 1'b0, "R7", rb);
        cs_high();
        chk(cfg_q == model_flat(), "R7", "partial write", cfg_q, model_flat());

        // R7 abort during read data: pin released
        cs_low();
        do_byte({1'b1, 2'd3, 5'd1}, model_lsb, 1'b0, "R7", r);
        for (int i = 0; i < 3; i++) do_bit(1'b0, 1'b1, "R7", rb);
        cs_high();
        chk(sdio_oe == 1'b0, "R7", "enable after abort", 256'(sdio_oe), 256'(0));

        // R7 next transaction decodes a fresh instruction
        xact({1'b0, 2'd0, 5'd7, 32'h00000081}, "R7");

        // R8 extra write byte past the count is ignored
        cs_low();
        do_byte({1'b0, 2'd0, 5'd9}, model_lsb, 1'b0, "R8", r);
        do_byte(8'h12, model_lsb, 1'b0, "R8", r);
        model[9] = 8'h12;
        do_byte(8'hFF, model_lsb, 1'b0, "R8", r);
        cs_high();
        chk(cfg_q == model_flat(), "R8", "write overrun", cfg_q, model_flat());

        // R8 extra read bits do not drive the pin
        cs_low();
        do_byte({1'b1, 2'd0, 5'd9}, model_lsb, 1'b0, "R8", r);
        do_byte(8'h00, model_lsb, 1'b1, "R8", r);
        chk(r == 8'h12, "R8", "read byte", 256'(r), 256'h12);
        do_byte(8'h00, model_lsb, 1'b0, "R8", r);
        cs_high();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule